// File: doc/BRIEF.md
# Serial Configuration Port with Register File

This block takes configuration writes from a write-only three-wire serial master (active-low chip select, serial clock and serial data) and keeps them in a file of fifteen 10-bit registers. Their contents drive the rest of a sensor signal chain as one flat bus. Each frame carries 16 bits. It opens with two bits that the block ignores, then gives a 4-bit register address, then 10 data bits.

All three serial lines are sampled in the system clock domain through synchronizers. The block detects the leading edge of the serial clock there. A pin selects the idle level of that clock. A frame takes effect only when chip select rises after exactly sixteen leading edges.

Every register has its own reset value. Three events restore those values: the system reset, a separate active-low hardware reset pin, and a self-clearing software-reset bit in control register 0. A second self-clearing bit in the same register issues a one-cycle pulse that clears the black-level result downstream.

Top module: `cfg_serial_regfile`

## Requirements
- R1: Frames are shifted MSB first. Of the 16 bits, bits 15..14 are ignored, bits 13..10 are the address and bits 9..0 are the data.
- R2: A frame is committed only when chip select rises after exactly 16 leading clock edges. Frames with 15 or 17 edges change no register.
- R3: When sp_pol is 1, the clock idles low and data is taken on the rising edge. When sp_pol is 0, the clock idles high and data is taken on the falling edge.
- R4: Register k appears on cfg_bus[10k+9:10k]. A write to address k in the range 1..14 stores all 10 data bits in register k.
- R5: After rst, registers 6, 7, 8, 9 and 14 hold 0x040, 0x003, 0x3FF, 0x3FF and 0x200. All other registers hold zero, and black_clr is 0.
- R6: Holding hw_rst_n low restores every register to its R5 value.
- R7: A write to address 0 with data bit 0 set restores every register to its R5 value, register 0 included. It issues no black_clr pulse.
- R8: A write to address 0 with bit 0 clear and bit 1 set produces exactly one single-cycle pulse on black_clr. Register 0 then stores the data with bits 1..0 forced to zero.
- R9: A write to address 15 changes no register.
- R10: With bit 9 of register 0 set (standby), writes to the other registers are still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_rst_n | input | 1 | Asynchronous active-low hardware reset pin, synchronized inside |
| sp_cs_n | input | 1 | Serial chip select, active low |
| sp_sclk | input | 1 | Serial clock |
| sp_sdin | input | 1 | Serial data |
| sp_pol | input | 1 | Serial clock idle level select (1: idles low) |
| cfg_bus | output | 150 | All fifteen registers, register k at bits 10k+9..10k |
| black_clr | output | 1 | One-cycle black-result clear pulse |

## Verification
The assertions assume that the serial lines change slowly compared with the system clock. Each serial clock phase, and each gap between a chip select edge and a clock edge, must last longer than the synchronizer depth. They also assume that data is stable across the leading edge and that sp_pol changes only while chip select is high. The stimulus holds every serial phase for four system cycles and sets up data one phase ahead of each edge. It changes the polarity only during the idle gap before chip select falls, and it leaves enough idle cycles after each frame for the commit to land before anything is sampled.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int CFG_DW     = 10;
  localparam int CFG_AW     = 4;
  localparam int CFG_NREG   = 15;
  localparam int CFG_FRAME  = 16;

  // Reset value of each configuration register
  function automatic logic [15:0] reg_default(input int idx);
    case (idx)
      6:       return 16'h0040;
      7:       return 16'h0003;
      8, 9:    return 16'h03FF;
      14:      return 16'h0200;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/cfgp_rx.sv
module cfgp_rx #(
  parameter int AW         = 4,
  parameter int DW         = 10,
  parameter int FRAME_BITS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n_s,
  input  logic          sck_s,
  input  logic          sdi_s,
  input  logic          pol_s,
  output logic          frame_vld,
  output logic [AW-1:0] frame_addr,
  output logic [DW-1:0] frame_data
);
  localparam int SH_W = AW + DW;
  localparam int CW   = $clog2(FRAME_BITS + 2);
  localparam logic [CW-1:0] FULL = CW'(FRAME_BITS);
  localparam logic [CW-1:0] OVER = CW'(FRAME_BITS + 1);

  logic          norm, norm_d, cs_d, lead;
  logic [SH_W-1:0] sh;
  logic [CW-1:0]   cnt;

  // Normalize so the leading edge is always a rising edge
  assign norm = pol_s ? sck_s : ~sck_s;
  assign lead = norm & ~norm_d & ~cs_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      norm_d    <= 1'b0;
      cs_d      <= 1'b1;
      cnt       <= '0;
      sh        <= '0;
      frame_vld <= 1'b0;
    end else begin
      norm_d    <= norm;
      cs_d      <= cs_n_s;
      frame_vld <= 1'b0;
      if (cs_n_s) begin
        cnt <= '0;
        if (!cs_d && cnt == FULL) frame_vld <= 1'b1;
      end else if (lead) begin
        sh <= {sh[SH_W-2:0], sdi_s};
        if (cnt != OVER) cnt <= cnt + 1'b1;
      end
    end
  end

  assign frame_addr = sh[DW +: AW];
  assign frame_data = sh[DW-1:0];

  // R2
  commit_idle_chk: assert property (@(posedge clk) disable iff (rst)
    frame_vld |-> (cs_d && cs_n_s));
  // R2
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (cnt == '0));
endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
  import cfgp_pkg::*;
#(
  parameter int AW   = 4,
  parameter int DW   = 10,
  parameter int NREG = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hw_rst,
  input  logic               wr_vld,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  output logic [NREG*DW-1:0] cfg_bus,
  output logic               black_clr
);
  localparam logic [DW-1:0] CTRL_KEEP = ~DW'(3);

  logic [DW-1:0]      regs [NREG];
  logic [NREG*DW-1:0] def_bus;
  logic               addr_ok;

  assign addr_ok = wr_addr < AW'(NREG);

  always_ff @(posedge clk) begin
    if (rst || hw_rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= DW'(reg_default(i));
      black_clr <= 1'b0;
    end else begin
      black_clr <= 1'b0;
      if (wr_vld && addr_ok) begin
        if (wr_addr == '0 && wr_data[0]) begin
          for (int i = 0; i < NREG; i++) regs[i] <= DW'(reg_default(i));
        end else begin
          for (int i = 0; i < NREG; i++) begin
            if (wr_addr == AW'(i))
              regs[i] <= (i == 0) ? (wr_data & CTRL_KEEP) : wr_data;
          end
          if (wr_addr == '0) black_clr <= wr_data[1];
        end
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_bus
    assign cfg_bus[g*DW +: DW] = regs[g];
    assign def_bus[g*DW +: DW] = DW'(reg_default(g));
  end

  // R4
  for (genvar g = 1; g < NREG; g++) begin : g_wr_chk
    reg_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_vld && wr_addr == AW'(g) && !hw_rst) |=> (regs[g] == $past(wr_data)));
  end
  // R9
  high_addr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && !addr_ok && !hw_rst) |=> $stable(cfg_bus));
  // R7
  soft_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && wr_addr == '0 && wr_data[0]) |=> (cfg_bus == def_bus && !black_clr));
  // R6
  hw_rst_chk: assert property (@(posedge clk) disable iff (rst)
    hw_rst |=> (cfg_bus == def_bus));
  // R8
  clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    black_clr |=> !black_clr);
endmodule

// File: rtl/cfg_serial_regfile.sv
module cfg_serial_regfile #(
  parameter int DATA_W      = cfgp_pkg::CFG_DW,
  parameter int ADDR_W      = cfgp_pkg::CFG_AW,
  parameter int NUM_REGS    = cfgp_pkg::CFG_NREG,
  parameter int FRAME_BITS  = cfgp_pkg::CFG_FRAME,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       hw_rst_n,
  input  logic                       sp_cs_n,
  input  logic                       sp_sclk,
  input  logic                       sp_sdin,
  input  logic                       sp_pol,
  output logic [NUM_REGS*DATA_W-1:0] cfg_bus,
  output logic                       black_clr
);
  localparam int BUS_W = NUM_REGS * DATA_W;

  logic [3:0]          pins_s;
  logic                hw_n_s;
  logic                frame_vld;
  logic [ADDR_W-1:0]   frame_addr;
  logic [DATA_W-1:0]   frame_data;
  logic [BUS_W-1:0]    bus_int;

  cfgp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_pin_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sp_cs_n, sp_sclk, sp_sdin, sp_pol}),
    .q   (pins_s)
  );

  cfgp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hwrst_sync (
    .clk (clk),
    .rst (rst),
    .d   (hw_rst_n),
    .q   (hw_n_s)
  );

  cfgp_rx #(.AW(ADDR_W), .DW(DATA_W), .FRAME_BITS(FRAME_BITS)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .cs_n_s     (pins_s[3]),
    .sck_s      (pins_s[2]),
    .sdi_s      (pins_s[1]),
    .pol_s      (pins_s[0]),
    .frame_vld  (frame_vld),
    .frame_addr (frame_addr),
    .frame_data (frame_data)
  );

  cfgp_regfile #(.AW(ADDR_W), .DW(DATA_W), .NREG(NUM_REGS)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .hw_rst    (~hw_n_s),
    .wr_vld    (frame_vld),
    .wr_addr   (frame_addr),
    .wr_data   (frame_data),
    .cfg_bus   (bus_int),
    .black_clr (black_clr)
  );

  assign cfg_bus = bus_int;
endmodule

// File: tb/cfg_serial_regfile_tb_top.sv
`timescale 1ns/1ps
module cfg_serial_regfile_tb_top;
  localparam int NR = 15;
  localparam int DW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hw_rst_n = 1'b1;
  logic sp_cs_n = 1'b1;
  logic sp_sclk = 1'b0;
  logic sp_sdin = 1'b0;
  logic sp_pol = 1'b1;
  logic [NR*DW-1:0] cfg_bus;
  logic black_clr;

  int n_chk = 0;
  int n_bad = 0;
  int pulses = 0;
  int run_len = 0;
  int max_w = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_r [NR];

  always #2 clk = ~clk;

  cfg_serial_regfile dut_i (
    .clk(clk), .rst(rst), .hw_rst_n(hw_rst_n), .sp_cs_n(sp_cs_n),
    .sp_sclk(sp_sclk), .sp_sdin(sp_sdin), .sp_pol(sp_pol),
    .cfg_bus(cfg_bus), .black_clr(black_clr)
  );

  always @(posedge clk) begin
    if (black_clr) begin
      pulses++;
      run_len++;
      if (run_len > max_w) max_w = run_len;
    end else begin
      run_len = 0;
    end
  end

  function automatic logic [DW-1:0] dflt(input int i);
    if (i == 6) return 10'h040;
    if (i == 7) return 10'h003;
    if (i == 8 || i == 9) return 10'h3FF;
    if (i == 14) return 10'h200;
    return 10'h000;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int i = 0; i < NR; i++) chk(req, 32'(cfg_bus[i*DW +: DW]), 32'(exp_r[i]));
  endtask

  task automatic load_defaults();
    for (int i = 0; i < NR; i++) exp_r[i] = dflt(i);
  endtask

  task automatic send(input logic [3:0] a, input logic [9:0] d, input int nbits,
                      input logic pol, input logic [1:0] nulls);
    logic [15:0] fr;
    fr = {nulls, a, d};
    sp_pol  = pol;
    sp_sclk = ~pol;
    cyc(6);
    sp_cs_n = 1'b0;
    cyc(4);
    for (int b = 0; b < nbits; b++) begin
      sp_sdin = (b < 16) ? fr[15-b] : 1'b1;
      cyc(4);
      sp_sclk = pol;
      cyc(4);
      sp_sclk = ~pol;
    end
    cyc(4);
    sp_cs_n = 1'b1;
    cyc(14);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int p0;
    void'($urandom(32'h5EED_0C0F));
    load_defaults();
    cyc(5);
    rst = 1'b0;
    cyc(6);
    // R5 reset state
    chk_all("R5");
    chk("R5 black_clr", 32'(black_clr), 0);

    // R1 R3 idle-low clock, nonzero null bits ignored
    send(4'd1, 10'h2A5, 16, 1'b1, 2'b11);
    exp_r[1] = 10'h2A5;
    chk_all("R1 R3 pol1");
    // R3 idle-high clock
    send(4'd2, 10'h15A, 16, 1'b0, 2'b01);
    exp_r[2] = 10'h15A;
    chk_all("R3 pol0");

    // R2 short and long frames discarded
    send(4'd3, 10'h3C3, 15, 1'b1, 2'b00);
    chk_all("R2 short");
    send(4'd3, 10'h0F0, 17, 1'b0, 2'b00);
    chk_all("R2 long");

    // R9 address 15 ignored
    send(4'd15, 10'h3FF, 16, 1'b1, 2'b00);
    chk_all("R9");

    // R10 standby set, other writes still stored
    send(4'd0, 10'h200, 16, 1'b1, 2'b00);
    exp_r[0] = 10'h200;
    send(4'd5, 10'h123, 16, 1'b0, 2'b00);
    exp_r[5] = 10'h123;
    chk_all("R10");

    // R8 black clear strobe, low bits not stored
    p0 = pulses;
    max_w = 0;
    send(4'd0, 10'h20E, 16, 1'b1, 2'b00);
    exp_r[0] = 10'h20C;
    chk_all("R8 reg");
    chk("R8 pulse count", 32'(pulses - p0), 1);
    chk("R8 pulse width", 32'(max_w), 1);

    // R4 random writes, occasional malformed frames
    for (int k = 0; k < 60; k++) begin
      logic [3:0] a;
      logic [9:0] d;
      int nb;
      int sel;
      a   = 4'(($urandom % 14) + 1);
      d   = 10'($urandom);
      sel = $urandom % 8;
      nb  = (sel == 0) ? 15 : ((sel == 1) ? 17 : 16);
      send(a, d, nb, 1'($urandom), 2'($urandom));
      if (nb == 16) exp_r[a] = d;
      chk_all(nb == 16 ? "R4 random" : "R2 random");
    end

    // R7 software reset
    p0 = pulses;
    send(4'd0, 10'h003, 16, 1'b1, 2'b00);
    load_defaults();
    chk_all("R7");
    chk("R7 no pulse", 32'(pulses - p0), 0);

    // R6 hardware reset pin
    send(4'd8, 10'h011, 16, 1'b0, 2'b00);
    send(4'd13, 10'h0AA, 16, 1'b1, 2'b00);
    exp_r[8] = 10'h011;
    exp_r[13] = 10'h0AA;
    chk_all("R4 pre-hw");
    hw_rst_n = 1'b0;
    cyc(4);
    hw_rst_n = 1'b1;
    cyc(6);
    load_defaults();
    chk_all("R6");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule